// File: doc/BRIEF.md
# Carry Bypass Adder

A purely combinational binary adder of parameterised width. It is built as a chain of identical four-bit sections. Each section forms a generate term (a AND b) and an inclusive-OR propagate term (a OR b) for every bit. From these it ripples its internal carries and forms its sum bits with a separate exclusive-OR path. It also reduces the bit terms into one group generate and one group propagate.

The carry leaving a section is taken from the group terms: group generate OR (group propagate AND section carry-in). That carry is the next section's carry-in, so the chain skips over sections whose carry is decided by their operands alone. Because the propagate is an OR rather than an XOR, the group logic is an algebraic factoring of the ripple carry and gives exactly the same value.

The default width is 28 bits, which is seven sections. Any positive multiple of four may be chosen.

Top module: `carry_bypass_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `a_i + b_i + cin_i`.
- R2: `cout_o` equals bit `WIDTH` of the full-precision sum `a_i + b_i + cin_i`.
- R3: `WIDTH` is a positive multiple of 4, and the block is built from `WIDTH/4` identical sections; the default is 28 bits in seven sections, with the carry crossing all of them.
- R4: Per bit, the generate term is a AND b and the propagate term is a OR b; the carry out of a bit is generate OR (propagate AND the bit's carry-in).
- R5: The group propagate is the AND of the four bit propagates. When every bit of a section has at least one operand bit set and its carry-in is 1, its carry-out is 1.
- R6: The group generate is g3 | p3·g2 | p3·p2·g1 | p3·p2·p1·g0, with bit 3 the most significant bit of the section. The section carry-out is group generate OR (group propagate AND section carry-in), feeds the next section, and equals the section's internal ripple carry.
- R7: Each sum bit is a XOR b XOR that bit's internal carry-in, formed apart from the OR-based propagate.
- R8: A section whose group generate and group propagate are both 0 sends out a carry of 0 whatever its carry-in. For example, zero operands with `cin_i`=1 give `sum_o`=1 and `cout_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | first operand |
| b_i | input | WIDTH | second operand |
| cin_i | input | 1 | carry into the least significant section |
| sum_o | output | WIDTH | sum bits |
| cout_o | output | 1 | carry out of the most significant section |

## Verification
Random operand pairs with both carry-in values cover the general arithmetic. The all-ones plus one case forces a carry through all seven bypass stages, and so separates a correct chain from one that stops early. Complementary alternating-bit operands make every bit propagate and none generate, so the carry-in alone decides the whole result. This separates an OR-based group propagate from a faulty one. Zero operands with carry-in set, all-ones operands, and single-section generate patterns check the kill, saturation and group-generate cases.

// File: rtl/cba_pkg.sv
package cba_pkg;
  localparam int unsigned SEC_W = 4;

  typedef struct packed {
    logic g;
    logic p;
  } pg_t;
endpackage

// File: rtl/cba_bit_pg.sv
module cba_bit_pg
  import cba_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  output pg_t  pg_o
);
  always_comb begin
    pg_o.g = a_i & b_i;
    pg_o.p = a_i | b_i;  // inclusive OR keeps the bypass a pure factoring
  end
endmodule

// File: rtl/cba_section.sv
module cba_section
  import cba_pkg::*;
#(
  parameter int unsigned W = SEC_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  pg_t [W-1:0] pg;
  logic [W:0]  rc;
  logic        grp_g;
  logic        grp_p;

  for (genvar i = 0; i < W; i++) begin : gen_bit
    cba_bit_pg u_pg (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .pg_o (pg[i])
    );
  end

  // internal ripple and sums
  always_comb begin
    rc[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      rc[i+1]  = pg[i].g | (pg[i].p & rc[i]);
      sum_o[i] = a_i[i] ^ b_i[i] ^ rc[i];
    end
  end

  // group terms, nested form of g3 | p3 g2 | p3 p2 g1 | p3 p2 p1 g0
  always_comb begin
    grp_g = 1'b0;
    grp_p = 1'b1;
    for (int i = 0; i < W; i++) begin
      grp_g = pg[i].g | (pg[i].p & grp_g);
      grp_p = grp_p & pg[i].p;
    end
  end

  assign cout_o = grp_g | (grp_p & cin_i);

  always_comb begin
    assert_bypass_match_R6: assert (cout_o == rc[W])
      else $error("bypass carry differs from ripple carry");
    assert_grp_gen_R6: assert (!grp_g || rc[W])
      else $error("group generate without ripple carry");
    assert_grp_prop_R5: assert (!(grp_p && cin_i) || cout_o)
      else $error("propagating section dropped carry");
    assert_no_carry_R8: assert (grp_g || grp_p || !cout_o)
      else $error("killed section sent carry");
    assert_sec_sum_R7: assert ({rc[W], sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("section sum wrong");
  end
endmodule

// File: rtl/carry_bypass_adder.sv
module carry_bypass_adder
  import cba_pkg::*;
#(
  parameter int unsigned WIDTH = 28
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NSEC = WIDTH / SEC_W;

  for (genvar s = 0; s < NSEC; s++) begin : gen_sec
    logic ci;
    logic co;
    if (s == 0) begin : gen_first
      assign ci = cin_i;
    end else begin : gen_next
      assign ci = gen_sec[s-1].co;
    end
    cba_section #(.W(SEC_W)) u_sec (
      .a_i    (a_i[s*SEC_W +: SEC_W]),
      .b_i    (b_i[s*SEC_W +: SEC_W]),
      .cin_i  (ci),
      .sum_o  (sum_o[s*SEC_W +: SEC_W]),
      .cout_o (co)
    );
  end

  assign cout_o = gen_sec[NSEC-1].co;

  logic [WIDTH:0] full_sum;
  always_comb begin
    full_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    assert_total_R1: assert (sum_o == full_sum[WIDTH-1:0])
      else $error("sum bits wrong");
    assert_cout_R2: assert (cout_o == full_sum[WIDTH])
      else $error("carry-out wrong");
  end
endmodule

// File: tb/carry_bypass_adder_test.sv
module carry_bypass_adder_test;
  localparam int W = 28;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_bypass_adder #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  // behavioural reference: integer addition in 64 bits
  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string tag);
    longint unsigned exp_full;
    logic [W-1:0] exp_sum;
    logic exp_c;
    @(posedge clk);
    a <= av; b <= bv; cin <= cv;
    exp_full = longint'(av) + longint'(bv) + longint'(cv);
    exp_sum  = exp_full[W-1:0];
    exp_c    = exp_full[W];
    @(negedge clk);
    checks++;
    if (sum !== exp_sum) begin
      fails++;
      $display("FAIL %s R1 sum: got %h expected %h", tag, sum, exp_sum);
    end
    checks++;
    if (cout !== exp_c) begin
      fails++;
      $display("FAIL %s R2 cout: got %b expected %b", tag, cout, exp_c);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    checks++;  // R1 idle state with zero inputs
    if (sum !== '0 || cout !== 1'b0) begin
      fails++;
      $display("FAIL R1 initial: got %b_%h expected 0_0000000", cout, sum);
    end
    apply('0, '0, 1'b1, "R8 kill");
    apply({W{1'b1}}, '0, 1'b1, "R3 seven-section carry");
    apply({W{1'b1}}, {W{1'b1}}, 1'b0, "R4 all ones");
    apply({W{1'b1}}, {W{1'b1}}, 1'b1, "R4 all ones cin");
    apply({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b0, "R5 alternating");
    apply({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b1, "R5 alternating cin");
    apply({(W/2){2'b10}}, {(W/2){2'b10}}, 1'b1, "R7 alt same");
    for (int s = 0; s < W/4; s++) begin
      apply(W'(28'h8) << (4*s), W'(28'h8) << (4*s), 1'b0, "R6 g3");
      apply((W'(28'h1) << (4*s)) | (W'(28'hE) << (4*s)),
            W'(28'h1) << (4*s), 1'b0, "R6 g0 through p1-p3");
    end
    for (int i = 0; i < 400; i++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule